// File: doc/BRIEF.md
# GPIO Edge Interrupt Controller

This block turns the already-conditioned input pins of one port group into interrupt requests. Each pin has three pieces of state. A polarity bit chooses whether a rising or a falling transition counts. A mask bit decides whether that pin may raise the CPU request. A sticky pending flag records that the chosen transition took place. Software clears a pending flag by writing a one to its bit position.

A summary output reports that at least one pin in the group has a pending flag, whether or not that pin is masked. The CPU request is the OR of all pending flags whose mask bit is set. Because flags are recorded even on masked pins, software can poll those pins.

Software reaches the block through a small synchronous write port with an address, and a combinational read port on the same address. Transitions are detected by comparing each pin with the value it had one clock earlier.

Top module: `gpio_edge_irq_ctrl`

## Requirements
- R1: After reset, every register reads as zero, and `irq_o` and `grp_flag_o` are low.
- R2: When a pin's polarity bit is 0, a low-to-high change on that pin sets its pending flag at the clock edge where the high level is first sampled.
- R3: When a pin's polarity bit is 1, a high-to-low change sets its pending flag. A change in the other direction leaves the flag unchanged.
- R4: Writing to address 2 clears every pending flag whose data bit is 1. Flags whose data bit is 0 keep their value. Without such a write, a set flag stays set.
- R5: `irq_o` is high exactly when some pin has both its pending flag and its mask bit set. Pending flags are recorded on masked-off pins too.
- R6: `grp_flag_o` is high exactly when any pending flag is set. Address 3 returns this value in bit 0, with all other bits zero.
- R7: When a clear write and a detected transition hit the same flag in the same cycle, the flag ends up set.
- R8: In the cycle where a write to address 0 changes a pin's polarity bit, no transition is detected on that pin. Detection with the new polarity starts in the following cycle.
- R9: The pin levels present when reset ends are taken as the starting history. A pin that is already high, or that stays high, through reset does not set a flag.
- R10: Address map. Address 0 holds the polarity bits (bit i is pin i). Address 1 holds the mask bits. Address 2 holds the pending flags, cleared by writing one. Address 3 holds the summary. Addresses 0 and 1 read back the value that was written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_n_i | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| pin_i | input | NPIN | Conditioned pin levels |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Register address for write and read |
| wr_data_i | input | NPIN | Write data |
| rd_data_o | output | NPIN | Read data for `addr_i` |
| irq_o | output | 1 | Request to the CPU: OR of pending flags whose mask bit is set |
| grp_flag_o | output | 1 | High when any pending flag in the group is set |

## Verification
The bench builds the block with NPIN = 4. This small width lets each vector name every pin's expected flag outright. Within one short table it can mix both polarities, masked and unmasked pins, partial clears and a clear that collides with a transition. Directed runs then cover the same-cycle polarity change, a reset taken with pins held high, and read-back of every address. The default width of 8 changes only how many copies of the per-pin cell are generated.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  localparam int ADDR_W = 2;
  localparam logic [ADDR_W-1:0] ADDR_POL  = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_MASK = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_PEND = 2'd2;
  localparam logic [ADDR_W-1:0] ADDR_SUMM = 2'd3;
endpackage

// File: rtl/gpio_edge_det.sv
// Per-pin transition detector: one history flop per pin and a shared
// "history valid" bit, so the level seen when reset ends is never an edge.
module gpio_edge_det #(
  parameter int NPIN = 8
) (
  input  logic            clk_i,
  input  logic            rst_n,
  input  logic [NPIN-1:0] pin_i,
  input  logic [NPIN-1:0] pol_i,
  input  logic [NPIN-1:0] pol_chg_i,
  output logic [NPIN-1:0] det_o
);
  logic hist_vld_q, hist_vld_d;

  always_comb begin
    hist_vld_d = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) hist_vld_q <= 1'b0;
    else        hist_vld_q <= hist_vld_d;
  end

  for (genvar i = 0; i < NPIN; i++) begin : g_pin
    logic hist_q, hist_d;
    logic rise, fall;

    always_comb begin
      hist_d   = pin_i[i];
      rise     = ~hist_q & pin_i[i];
      fall     = hist_q & ~pin_i[i];
      det_o[i] = hist_vld_q & ~pol_chg_i[i] & (pol_i[i] ? fall : rise);
    end

    always_ff @(posedge clk_i or negedge rst_n) begin
      if (!rst_n) hist_q <= 1'b0;
      else        hist_q <= hist_d;
    end
  end
endmodule

// File: rtl/gpio_irq_regs.sv
// Polarity and mask registers, write decode and read mux.
module gpio_irq_regs
  import gpio_irq_pkg::*;
#(
  parameter int NPIN = 8
) (
  input  logic              clk_i,
  input  logic              rst_n,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [NPIN-1:0]   wr_data_i,
  input  logic [NPIN-1:0]   pend_i,
  input  logic              grp_i,
  output logic [NPIN-1:0]   pol_o,
  output logic [NPIN-1:0]   mask_o,
  output logic [NPIN-1:0]   pol_chg_o,
  output logic [NPIN-1:0]   clr_o,
  output logic [NPIN-1:0]   rd_data_o
);
  logic            pol_we, mask_we;
  logic [NPIN-1:0] pol_q, pol_d, mask_q, mask_d;

  always_comb begin
    pol_we    = wr_en_i && (addr_i == ADDR_POL);
    mask_we   = wr_en_i && (addr_i == ADDR_MASK);
    pol_d     = wr_data_i;
    mask_d    = wr_data_i;
    pol_chg_o = pol_we ? (wr_data_i ^ pol_q) : '0;
    clr_o     = (wr_en_i && (addr_i == ADDR_PEND)) ? wr_data_i : '0;
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n)      pol_q <= '0;
    else if (pol_we) pol_q <= pol_d;
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n)       mask_q <= '0;
    else if (mask_we) mask_q <= mask_d;
  end

  always_comb begin
    rd_data_o = '0;
    case (addr_i)
      ADDR_POL:  rd_data_o = pol_q;
      ADDR_MASK: rd_data_o = mask_q;
      ADDR_PEND: rd_data_o = pend_i;
      default:   rd_data_o[0] = grp_i;
    endcase
  end

  assign pol_o  = pol_q;
  assign mask_o = mask_q;
endmodule

// File: rtl/gpio_irq_flags.sv
// Sticky pending flags with write-one-to-clear; a detected edge wins over a clear.
module gpio_irq_flags #(
  parameter int NPIN = 8
) (
  input  logic            clk_i,
  input  logic            rst_n,
  input  logic [NPIN-1:0] det_i,
  input  logic [NPIN-1:0] clr_i,
  input  logic [NPIN-1:0] mask_i,
  output logic [NPIN-1:0] pend_o,
  output logic            irq_o,
  output logic            grp_o
);
  logic            pend_we;
  logic [NPIN-1:0] pend_q, pend_d;

  always_comb begin
    pend_we = (|clr_i) | (|det_i);
    pend_d  = (pend_q & ~clr_i) | det_i;
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n)       pend_q <= '0;
    else if (pend_we) pend_q <= pend_d;
  end

  always_comb begin
    irq_o  = |(pend_q & mask_i);
    grp_o  = |pend_q;
    pend_o = pend_q;
  end
endmodule

// File: rtl/gpio_edge_irq_ctrl.sv
module gpio_edge_irq_ctrl
  import gpio_irq_pkg::*;
#(
  parameter int NPIN = 8
) (
  input  logic              clk_i,
  input  logic              rst_n_i,
  input  logic [NPIN-1:0]   pin_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [NPIN-1:0]   wr_data_i,
  output logic [NPIN-1:0]   rd_data_o,
  output logic              irq_o,
  output logic              grp_flag_o
);
  logic [1:0]      rst_sync_q;
  logic            rst_n;
  logic [NPIN-1:0] pol, mask, pol_chg, clr, det, pend;
  logic            grp;

  // Assert asynchronously, release on the second clock edge.
  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) rst_sync_q <= 2'b00;
    else          rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n = rst_sync_q[1];

  gpio_irq_regs #(.NPIN(NPIN)) u_regs (
    .clk_i(clk_i), .rst_n(rst_n), .wr_en_i(wr_en_i), .addr_i(addr_i),
    .wr_data_i(wr_data_i), .pend_i(pend), .grp_i(grp), .pol_o(pol),
    .mask_o(mask), .pol_chg_o(pol_chg), .clr_o(clr), .rd_data_o(rd_data_o)
  );

  gpio_edge_det #(.NPIN(NPIN)) u_det (
    .clk_i(clk_i), .rst_n(rst_n), .pin_i(pin_i), .pol_i(pol),
    .pol_chg_i(pol_chg), .det_o(det)
  );

  gpio_irq_flags #(.NPIN(NPIN)) u_flags (
    .clk_i(clk_i), .rst_n(rst_n), .det_i(det), .clr_i(clr), .mask_i(mask),
    .pend_o(pend), .irq_o(irq_o), .grp_o(grp)
  );

  assign grp_flag_o = grp;
endmodule

// File: rtl/gpio_edge_irq_chk.sv
module gpio_edge_irq_chk
  import gpio_irq_pkg::*;
#(
  parameter int NPIN = 8
) (
  input logic              clk_i,
  input logic              rst_n,
  input logic              wr_en_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [NPIN-1:0]   wr_data_i,
  input logic [NPIN-1:0]   det,
  input logic [NPIN-1:0]   pend,
  input logic [NPIN-1:0]   mask,
  input logic              irq_o,
  input logic              grp_flag_o
);
  p_irq_needs_mask_r5: assert property (@(posedge clk_i) disable iff (!rst_n)
    irq_o |-> ((pend & mask) != '0));

  p_irq_when_armed_r5: assert property (@(posedge clk_i) disable iff (!rst_n)
    ((pend & mask) != '0) |-> irq_o);

  p_group_summary_r6: assert property (@(posedge clk_i) disable iff (!rst_n)
    grp_flag_o == (pend != '0));

  p_flag_sticky_r4: assert property (@(posedge clk_i) disable iff (!rst_n)
    !(wr_en_i && addr_i == ADDR_PEND) |=> ((pend & $past(pend)) == $past(pend)));

  p_w1c_clears_r4: assert property (@(posedge clk_i) disable iff (!rst_n)
    (wr_en_i && addr_i == ADDR_PEND) |=> ((pend & $past(wr_data_i & ~det)) == '0));

  p_edge_wins_r7: assert property (@(posedge clk_i) disable iff (!rst_n)
    (det != '0) |=> ((pend & $past(det)) == $past(det)));
endmodule

bind gpio_edge_irq_ctrl gpio_edge_irq_chk #(.NPIN(NPIN)) u_chk (
  .clk_i(clk_i), .rst_n(rst_n), .wr_en_i(wr_en_i), .addr_i(addr_i),
  .wr_data_i(wr_data_i), .det(det), .pend(pend), .mask(mask),
  .irq_o(irq_o), .grp_flag_o(grp_flag_o)
);

// File: tb/tb_gpio_edge_irq_ctrl.sv
`timescale 1ns/100ps
module tb_gpio_edge_irq_ctrl;
  localparam int NP = 4;

  logic          clk_i = 1'b0;
  logic          rst_n_i;
  logic [NP-1:0] pin_i;
  logic          wr_en_i;
  logic [1:0]    addr_i;
  logic [NP-1:0] wr_data_i;
  logic [NP-1:0] rd_data_o;
  logic          irq_o, grp_flag_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #2 clk_i = ~clk_i;

  gpio_edge_irq_ctrl #(.NPIN(NP)) dut (
    .clk_i(clk_i), .rst_n_i(rst_n_i), .pin_i(pin_i), .wr_en_i(wr_en_i),
    .addr_i(addr_i), .wr_data_i(wr_data_i), .rd_data_o(rd_data_o),
    .irq_o(irq_o), .grp_flag_o(grp_flag_o)
  );

  // Row: pins[15:12] wr[11] addr[10:9] wdata[8:5] exp_pend[4:1] exp_irq[0]
  // Setup before the table: polarity = 1100, mask = 0101, pins at 0000.
  localparam int NV = 12;
  localparam logic [15:0] VEC [NV] = '{
    {4'b0000, 1'b0, 2'd0, 4'b0000, 4'b0000, 1'b0}, // idle
    {4'b0001, 1'b0, 2'd0, 4'b0000, 4'b0001, 1'b1}, // R2 pin0 rises
    {4'b0011, 1'b0, 2'd0, 4'b0000, 4'b0011, 1'b1}, // R2 pin1 rises, masked
    {4'b1111, 1'b0, 2'd0, 4'b0000, 4'b0011, 1'b1}, // R3 rise ignored on falling pins
    {4'b1011, 1'b0, 2'd0, 4'b0000, 4'b0111, 1'b1}, // R3 pin2 falls
    {4'b1011, 1'b1, 2'd2, 4'b0001, 4'b0110, 1'b1}, // R4 clear pin0 only
    {4'b1011, 1'b1, 2'd2, 4'b0100, 4'b0010, 1'b0}, // R5 masked flag, no irq
    {4'b0011, 1'b1, 2'd2, 4'b0000, 4'b1010, 1'b0}, // R4 zero write keeps, pin3 falls
    {4'b0011, 1'b1, 2'd2, 4'b1010, 4'b0000, 1'b0}, // R4 clear two
    {4'b0010, 1'b0, 2'd0, 4'b0000, 4'b0000, 1'b0}, // R2 fall on rising pin ignored
    {4'b0011, 1'b1, 2'd2, 4'b0001, 4'b0001, 1'b1}, // R7 edge beats clear
    {4'b0011, 1'b1, 2'd2, 4'b1111, 4'b0000, 1'b0}  // R4 clear all
  };

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // One clock: drive at the falling edge, then leave the read port on the flags.
  task automatic step(logic [NP-1:0] p, logic w, logic [1:0] a, logic [NP-1:0] d);
    @(negedge clk_i);
    pin_i = p; wr_en_i = w; addr_i = a; wr_data_i = d;
    @(posedge clk_i);
    #1;
    wr_en_i = 1'b0; addr_i = 2'd2;
    #0.5;
  endtask

  task automatic rd(logic [1:0] a, output logic [NP-1:0] v);
    addr_i = a;
    #0.2;
    v = rd_data_o;
  endtask

  task automatic do_reset(logic [NP-1:0] p);
    @(negedge clk_i);
    rst_n_i = 1'b0; pin_i = p; wr_en_i = 1'b0; addr_i = 2'd2; wr_data_i = '0;
    repeat (3) @(negedge clk_i);
    rst_n_i = 1'b1;
    repeat (4) step(p, 1'b0, 2'd0, '0);
  endtask

  initial begin
    #150000;
    if (!done) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [NP-1:0] v;
    rst_n_i = 1'b0; pin_i = '0; wr_en_i = 1'b0; addr_i = '0; wr_data_i = '0;
    do_reset('0);

    // R1 reset state
    for (int a = 0; a < 4; a++) begin
      rd(a[1:0], v);
      check("R1 reg", {28'd0, v}, 32'd0);
    end
    check("R1 irq", {31'd0, irq_o}, 32'd0);
    check("R1 grp", {31'd0, grp_flag_o}, 32'd0);

    // Table setup (R10 map: 0 polarity, 1 mask)
    step(4'b0000, 1'b1, 2'd0, 4'b1100);
    step(4'b0000, 1'b1, 2'd1, 4'b0101);

    for (int i = 0; i < NV; i++) begin
      logic [15:0] r;
      r = VEC[i];
      step(r[15:12], r[11], r[10:9], r[8:5]);
      rd(2'd2, v);
      check($sformatf("R2-7 row%0d pend", i), {28'd0, v}, {28'd0, r[4:1]});
      check($sformatf("R5 row%0d irq", i), {31'd0, irq_o}, {31'd0, r[0]});
      check($sformatf("R6 row%0d grp", i), {31'd0, grp_flag_o}, {31'd0, |r[4:1]});
    end

    // R9: pins high through reset, polarity rising after reset
    do_reset(4'b1111);
    rd(2'd2, v);
    check("R9 no flag from reset level", {28'd0, v}, 32'd0);
    check("R9 grp", {31'd0, grp_flag_o}, 32'd0);

    // R8: polarity change on pin0 in the same cycle that pin0 rises
    step(4'b0000, 1'b0, 2'd0, '0);
    rd(2'd2, v);
    check("R3 fall on rising pins ignored", {28'd0, v}, 32'd0);
    step(4'b0001, 1'b1, 2'd0, 4'b0001);
    rd(2'd2, v);
    check("R8 no flag on polarity change", {28'd0, v}, 32'd0);
    step(4'b0001, 1'b0, 2'd0, '0);
    rd(2'd2, v);
    check("R8 still clear", {28'd0, v}, 32'd0);
    step(4'b0000, 1'b0, 2'd0, '0);
    rd(2'd2, v);
    check("R8 new polarity active", {28'd0, v}, 32'd1);
    check("R5 masked pin no irq", {31'd0, irq_o}, 32'd0);

    // R10 read-back and R6 summary register
    rd(2'd0, v);
    check("R10 polarity readback", {28'd0, v}, 32'd1);
    step(4'b0000, 1'b1, 2'd1, 4'b1011);
    rd(2'd1, v);
    check("R10 mask readback", {28'd0, v}, 32'hb);
    check("R5 unmasked pending irq", {31'd0, irq_o}, 32'd1);
    rd(2'd3, v);
    check("R6 summary register", {28'd0, v}, 32'd1);
    step(4'b0000, 1'b1, 2'd2, 4'b0001);
    rd(2'd3, v);
    check("R6 summary cleared", {28'd0, v}, 32'd0);
    check("R4 irq dropped", {31'd0, irq_o}, 32'd0);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule